// File: doc/BRIEF.md
# Edge-Sensing External Interrupt Port

This block handles eight external pins, seven of which (positions 1 to 7) can act as interrupt sources while position 0 is a reserved spare. Each pin works either as general-purpose I/O or as an interrupt input. Software sets the pins up through a small byte-addressed register bus. Each input pin is synchronised and can be set to level, rising-edge, falling-edge or both-edge sensing.

In the edge modes a detected event is held in a sticky flag until software clears it by writing a one. In level mode the active-low pin state goes straight to the request. The block drives one request line per pin toward a separate priority controller. The output data register and the direction register drive the pin output buffers.

Top module: `extirq_port`

## Requirements
- R1: After reset every register reads 0, and `irq_req`, `pin_out` and `pin_oe` are 0.
- R2: A write takes effect at the clock edge where `bus_we` is high. Offset 0 holds trigger-mode bits [15:8] and offset 1 holds bits [7:0]. Offset 2 is direction, offset 3 is enable and offset 4 is output data. All of these read back their stored value, and offset 7 reads 0. `pin_oe` follows direction (1 = output) and `pin_out` follows output data.
- R3: Offset 5 reads the pin inputs through a two-flop synchroniser, so a change shows two clock edges later. Writes to offset 5 are ignored.
- R4: Pin n takes its mode from trigger bits [2n+1:2n]. The codes are 00 level, 01 rising, 10 falling and 11 both. In an edge mode, a matching transition sets flag bit n (offset 6) three clock edges after the pin changes.
- R5: Writing a 1 to a bit of offset 6 clears that flag. Writing a 0 leaves it unchanged.
- R6: If an edge is detected on a pin in the same cycle as a clear for that pin, the flag stays set.
- R7: In level mode no flag is set. The request is high while the synchronised pin is 0, the enable bit is 1 and the pin is an input. Writing a clear to offset 6 does not change it.
- R8: In edge modes the request equals flag AND enable. A flag is set whether or not the pin is enabled.
- R9: Position 0 never sets a flag and never raises a request, whatever its mode, enable or pin level.
- R10: A pin with direction 1 sets no flag and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_out | output | 8 | Pin output drive values |
| pin_oe | output | 8 | Pin output enables |
| irq_req | output | 8 | Per-pin interrupt requests; bit 0 always 0 |

## Verification
The assertions assume that `bus_we`, `bus_addr` and `bus_wdata` are stable around the clock edge and that they are single-cycle byte writes. They also assume that `pin_in` may change at any time, with the synchroniser taking care of it. The bench drives bus inputs and pins only at the falling edge and deasserts the write strobe right after each rising edge. Random stimulus mixes writes to every offset, including the read-only and unused ones, with slow pin toggles, so that transitions happen under all four modes and both directions.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int NPIN = 8;
  localparam int AW   = 3;

  localparam logic [AW-1:0] OFS_MODE_HI = 3'd0;
  localparam logic [AW-1:0] OFS_MODE_LO = 3'd1;
  localparam logic [AW-1:0] OFS_DIR     = 3'd2;
  localparam logic [AW-1:0] OFS_EN      = 3'd3;
  localparam logic [AW-1:0] OFS_DOUT    = 3'd4;
  localparam logic [AW-1:0] OFS_PIN     = 3'd5;
  localparam logic [AW-1:0] OFS_FLAG    = 3'd6;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_e;

  // edge match for one pin given the current and previous synchronised sample
  function automatic logic trig_hit(trig_e m, logic cur, logic prv);
    case (m)
      TRIG_RISE: return cur && !prv;
      TRIG_FALL: return !cur && prv;
      TRIG_BOTH: return cur != prv;
      default:   return 1'b0;
    endcase
  endfunction

  // request for one pin: level mode uses the active-low pin, edge modes the flag
  function automatic logic pin_request(trig_e m, logic is_out, logic en,
                                       logic cur, logic flag);
    if (is_out || !en) return 1'b0;
    return (m == TRIG_LEVEL) ? !cur : flag;
  endfunction
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_q;
  end

  assign sync_q = chain[STAGES-1];

  p_prev_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_q == $past(sync_q)));
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [W-1:0]   wdata,
  input  logic [W-1:0]   pin_sync,
  input  logic [W-1:0]   flags,
  output logic [2*W-1:0] mode_q,
  output logic [W-1:0]   dir_q,
  output logic [W-1:0]   en_q,
  output logic [W-1:0]   dout_q,
  output logic [W-1:0]   clr,
  output logic [W-1:0]   rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      dout_q <= '0;
    end else if (we) begin
      case (addr)
        OFS_MODE_HI: mode_q[2*W-1:W] <= wdata;
        OFS_MODE_LO: mode_q[W-1:0]   <= wdata;
        OFS_DIR:     dir_q           <= wdata;
        OFS_EN:      en_q            <= wdata;
        OFS_DOUT:    dout_q          <= wdata;
        default: ;
      endcase
    end
  end

  assign clr = (we && addr == OFS_FLAG) ? wdata : '0;

  always_comb begin
    case (addr)
      OFS_MODE_HI: rdata = mode_q[2*W-1:W];
      OFS_MODE_LO: rdata = mode_q[W-1:0];
      OFS_DIR:     rdata = dir_q;
      OFS_EN:      rdata = en_q;
      OFS_DOUT:    rdata = dout_q;
      OFS_PIN:     rdata = pin_sync;
      OFS_FLAG:    rdata = flags;
      default:     rdata = '0;
    endcase
  end

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_DIR) |=> (dir_q == $past(wdata)));
  p_pin_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_PIN) |=> ($stable(dir_q) && $stable(en_q) && $stable(dout_q) && $stable(mode_q)));
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*W-1:0] mode_q,
  input  logic [W-1:0]   dir_q,
  input  logic [W-1:0]   en_q,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   prv,
  input  logic [W-1:0]   clr,
  output logic [W-1:0]   flags,
  output logic [W-1:0]   req,
  output logic [W-1:0]   hit
);
  logic [W-1:0] flag_d;

  generate
    for (genvar n = 0; n < W; n++) begin : g_pin
      if (n == 0) begin : g_reserved
        assign hit[n] = 1'b0;
        assign req[n] = 1'b0;
      end else begin : g_live
        trig_e mode_n;
        assign mode_n = trig_e'(mode_q[2*n+1 -: 2]);
        assign hit[n] = !dir_q[n] && trig_hit(mode_n, cur[n], prv[n]);
        assign req[n] = pin_request(mode_n, dir_q[n], en_q[n], cur[n], flags[n]);

        p_edge_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
          hit[n] |=> flags[n]);
        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (hit[n] && clr[n]) |=> flags[n]);
        p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
          (clr[n] && !hit[n]) |=> !flags[n]);
        p_zero_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
          (!clr[n] && flags[n]) |=> flags[n]);
        p_level_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
          (mode_n == TRIG_LEVEL && !flags[n]) |=> !flags[n]);
        p_output_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
          dir_q[n] |-> !req[n]);
        p_edge_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
          (mode_n != TRIG_LEVEL && !dir_q[n]) |-> (req[n] == (flags[n] && en_q[n])));
      end
    end
  endgenerate

  assign flag_d = (flags & ~clr) | hit;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= flag_d;
  end

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[0] && !req[0]);
endmodule

// File: rtl/extirq_port.sv
module extirq_port
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] irq_req
);
  logic [NPIN-1:0]   pin_sync, pin_prev;
  logic [2*NPIN-1:0] mode_q;
  logic [NPIN-1:0]   dir_q, en_q, dout_q, clr, flags, hit;

  extirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in),
    .sync_q(pin_sync), .prev_q(pin_prev)
  );

  extirq_regs #(.W(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pin_sync(pin_sync), .flags(flags), .mode_q(mode_q), .dir_q(dir_q),
    .en_q(en_q), .dout_q(dout_q), .clr(clr), .rdata(bus_rdata)
  );

  extirq_detect #(.W(NPIN)) u_detect (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .dir_q(dir_q), .en_q(en_q),
    .cur(pin_sync), .prv(pin_prev), .clr(clr), .flags(flags),
    .req(irq_req), .hit(hit)
  );

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (irq_req == '0 && pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/extirq_port_test.sv
`timescale 1ns/1ps
module extirq_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'hFF;
  logic [7:0] pin_out, pin_oe, irq_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  logic [7:0]  m_s1, m_s2, m_p, m_dir, m_en, m_dat, m_flag;
  logic [15:0] m_par;

  always #2.5 clk = ~clk;

  extirq_port uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_req(irq_req)
  );

  function automatic logic edge_seen(logic [1:0] code, logic now_v, logic old_v);
    logic up, down;
    up   = now_v & ~old_v;
    down = old_v & ~now_v;
    return (code[0] & up) | (code[1] & down);
  endfunction

  function automatic logic [7:0] exp_req();
    logic [7:0] r = '0;
    for (int n = 1; n < 8; n++) begin
      logic [1:0] code = m_par[2*n +: 2];
      if (!m_dir[n] && m_en[n])
        r[n] = (code == 2'b00) ? ~m_s2[n] : m_flag[n];
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_read(int a);
    case (a)
      0: return m_par[15:8];
      1: return m_par[7:0];
      2: return m_dir;
      3: return m_en;
      4: return m_dat;
      5: return m_s2;
      6: return m_flag;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_p = 0; m_dir = 0; m_en = 0; m_dat = 0; m_flag = 0; m_par = 0;
  endtask

  task automatic model_clock();
    logic [7:0] hits = '0, clrs = '0;
    for (int n = 1; n < 8; n++)
      hits[n] = ~m_dir[n] & edge_seen(m_par[2*n +: 2], m_s2[n], m_p[n]);
    if (bus_we && bus_addr == 3'd6) clrs = bus_wdata;
    m_flag = (m_flag & ~clrs) | hits;
    if (bus_we) begin
      case (bus_addr)
        3'd0: m_par[15:8] = bus_wdata;
        3'd1: m_par[7:0]  = bus_wdata;
        3'd2: m_dir = bus_wdata;
        3'd3: m_en  = bus_wdata;
        3'd4: m_dat = bus_wdata;
        default: ;
      endcase
    end
    m_p = m_s2; m_s2 = m_s1; m_s1 = pin_in;
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_clock(); else model_reset();
    #1 bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic check_all(string tag);
    chk({tag, " R8 irq"}, irq_req, exp_req());
    chk({tag, " R2 pin_out"}, pin_out, m_dat);
    chk({tag, " R2 pin_oe"}, pin_oe, m_dir);
    for (int a = 0; a < 8; a++) begin
      bus_addr = a[2:0];
      #0.1;
      chk($sformatf("%s R2 read ofs %0d", tag, a), bus_rdata, exp_read(a));
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    run(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, literal and model
    chk("R1 irq", irq_req, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    check_all("R1");
    run(3);

    // R2: register write and read-back
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd4, 8'h96); wr(3'd2, 8'h81);
    check_all("R2");
    chk("R2 literal mode_lo", exp_read(1), 8'h3C);
    wr(3'd2, 8'h00); wr(3'd0, 8'h00); wr(3'd1, 8'h00);

    // R3: pin sampling and ignored write to offset 5
    pin_in = 8'h5A; step(); step();
    bus_addr = 3'd5; #0.1; chk("R3 pin two edges", bus_rdata, 8'h5A);
    wr(3'd5, 8'hFF);
    check_all("R3 write ignored");
    pin_in = 8'hFF; run(3);

    // R4/R8: pin 3 rising, pin 5 falling, pin 6 both, pin 2 level; enable all
    wr(3'd0, 8'b11_11_10_00);   // pin7 both, pin6 both, pin5 fall, pin4 level
    wr(3'd1, 8'b01_00_00_00);   // pin3 rise, others level
    wr(3'd3, 8'hFE);
    wr(3'd6, 8'hFF);
    pin_in = 8'b1101_0111; step(); step(); check_all("R4 before latch");
    step(); check_all("R4 after falls");
    bus_addr = 3'd6; #0.1; chk("R4 falling flag pin5", bus_rdata & 8'h20, 8'h20);
    pin_in = 8'hFF; run(3); check_all("R4 rising");
    bus_addr = 3'd6; #0.1; chk("R4 rising flag pin3", bus_rdata & 8'h08, 8'h08);

    // R5: write zero keeps, write one clears
    wr(3'd6, 8'h00); check_all("R5 zero write");
    wr(3'd6, 8'h08); check_all("R5 one write");
    bus_addr = 3'd6; #0.1; chk("R5 pin3 cleared", bus_rdata & 8'h08, 8'h00);
    wr(3'd6, 8'hFF);

    // R6: edge detected and clear in the same cycle
    pin_in = 8'hF7; run(3); wr(3'd6, 8'hFF);
    pin_in = 8'hFF; step(); step();
    wr(3'd6, 8'h08);
    bus_addr = 3'd6; #0.1; chk("R6 flag stays", bus_rdata & 8'h08, 8'h08);
    chk("R6 irq stays", irq_req & 8'h08, 8'h08);
    check_all("R6");

    // R7: level mode on pin 4
    wr(3'd6, 8'hFF);
    pin_in = 8'hEF; run(2);
    chk("R7 level irq", irq_req & 8'h10, 8'h10);
    wr(3'd6, 8'h10); check_all("R7 clear harmless");
    chk("R7 still high", irq_req & 8'h10, 8'h10);
    pin_in = 8'hFF; run(3); check_all("R7 release");

    // R9: reserved position 0 in both-edge mode, enabled
    wr(3'd1, 8'b01_00_00_11); wr(3'd3, 8'hFF); wr(3'd6, 8'hFF);
    for (int k = 0; k < 6; k++) begin pin_in[0] = ~pin_in[0]; run(3); end
    chk("R9 irq bit0", irq_req & 8'h01, 8'h00);
    check_all("R9");

    // R10: pin 6 set as output, both-edge mode
    wr(3'd2, 8'h40); wr(3'd6, 8'hFF);
    pin_in[6] = 1'b0; run(4); pin_in[6] = 1'b1; run(4);
    chk("R10 irq bit6", irq_req & 8'h40, 8'h00);
    check_all("R10");
    wr(3'd2, 8'h00);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        bus_we = 1'b1;
        bus_addr = 3'($urandom_range(0, 7));
        bus_wdata = 8'($urandom);
      end
      if ($urandom_range(0, 5) == 0) pin_in[$urandom_range(0, 7)] ^= 1'b1;
      step();
      if (i % 8 == 0) check_all("random");
      else chk("R8 random irq", irq_req, exp_req());
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule